// File: doc/BRIEF.md
# Endian Lane Steering Path

This block sits between the data-cache word port and the integer register file. It turns a 32-bit cache word into a register value for loads, and a register value into cache write data with byte enables for stores. It handles two things that reorder bytes: explicit byte-reversing halfword and word accesses, and a machine-wide little-endian mode. The default byte order is big-endian. Byte lane k of a cache word, bits [8k+7:8k], holds the byte at address offset k within that word.

The swap decision is the exclusive-OR of the explicit reverse flag and the little-endian mode bit. Setting both flags therefore cancels the reversal. Single-byte accesses are never reordered. Every access takes the same path: an input register, one combinational steering stage, and an output register. Reversed and plain loads therefore finish in the same cycle.

A separate combinational path feeds fetched instruction words to the decoder. When little-endian mode is on, this path reverses the bytes of the word.

Top module: `endian_lane_steer`

## Requirements
- R1: While rst_n is low, wb_valid, wb_data, st_valid, st_be and st_data are all zero.
- R2: A byte load (acc_size 0) returns lane addr_lo of cache_rdata, zero-extended to 32 bits. This holds for every setting of acc_brev and le_mode.
- R3: A halfword load (acc_size 1) with no swap returns {lane b, lane b+1}, zero-extended, where b = 2*addr_lo[1]. addr_lo[0] is ignored.
- R4: A halfword or word load where exactly one of acc_brev and le_mode is set returns the reversed order. For a halfword this is {lane b+1, lane b}, zero-extended. For a word it is cache_rdata unchanged.
- R5: A word load (acc_size 2, or the reserved code 3) with no swap returns {lane 0, lane 1, lane 2, lane 3}. addr_lo is ignored.
- R6: When acc_brev and le_mode are both set, loads and stores behave exactly as when both are clear.
- R7: An access presented on one rising edge produces its outputs on the following rising edge. Loads raise wb_valid and stores raise st_valid, each for one cycle. Latency does not depend on swapping.
- R8: Store byte enables are as follows. A byte store sets bit addr_lo. A halfword store sets 4'b0011 when addr_lo[1] is 0 and 4'b1100 when it is 1. A word store sets 4'b1111. When no store completes, st_be and st_data are zero.
- R9: Store data is placed as follows. A byte store puts store_src[7:0] in lane addr_lo. A halfword store with no swap puts store_src[15:8] in lane b and store_src[7:0] in lane b+1. A swapped halfword store puts the two bytes in the opposite lanes. A word store with no swap puts store_src[31:24] in lane 0 through store_src[7:0] in lane 3. A swapped word store puts store_src in place. Disabled lanes are zero.
- R10: decode_word equals fetch_word with its four bytes reversed while le_mode is 1. Otherwise it equals fetch_word unchanged. This path is combinational.
- R11: wb_data holds the last loaded value through cycles in which no load completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_store | input | 1 | 1 = store, 0 = load |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word (3 treated as word) |
| acc_brev | input | 1 | Explicit byte-reverse access |
| le_mode | input | 1 | Machine-wide little-endian mode |
| addr_lo | input | 2 | Low address bits of the access |
| cache_rdata | input | 32 | Word read from the data cache |
| store_src | input | 32 | Register value to be stored |
| fetch_word | input | 32 | Fetched instruction word |
| decode_word | output | 32 | Instruction word handed to the decoder |
| wb_valid | output | 1 | Load result valid |
| wb_data | output | 32 | Register writeback data |
| st_valid | output | 1 | Store data valid |
| st_be | output | 4 | Store byte enables, bit k = lane k |
| st_data | output | 32 | Cache write data |

## Verification
The bench covers every size, swap setting and alignment for both directions, and compares each result with a lane-by-lane model. It targets several specific mistakes:
- Applying both flags as two separate swaps instead of cancelling them would reverse data when both flags are set.
- Swapping single bytes would move the byte into the wrong lane.
- Sign-extending or keeping stale upper bytes on halfword loads would leave the upper 16 bits non-zero.
- Using addr_lo[0] for halfword selection would pick the wrong lane pair.

Directed cases show that a plain load and a reversed load both appear after exactly two edges, and that wb_data stays put across stores. They also check that the instruction path follows le_mode with no delay.

// File: rtl/endian_lane_steer.sv
module endian_lane_steer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_store,
  input  logic [1:0]  acc_size,
  input  logic        acc_brev,
  input  logic        le_mode,
  input  logic [1:0]  addr_lo,
  input  logic [31:0] cache_rdata,
  input  logic [31:0] store_src,
  input  logic [31:0] fetch_word,
  output logic [31:0] decode_word,
  output logic        wb_valid,
  output logic [31:0] wb_data,
  output logic        st_valid,
  output logic [3:0]  st_be,
  output logic [31:0] st_data
);
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  assign decode_word = le_mode ? bswap(fetch_word) : fetch_word;

  logic        s_valid, s_store, s_swap;
  logic [1:0]  s_size, s_addr;
  logic [31:0] s_rdata, s_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_store <= 1'b0;
      s_swap  <= 1'b0;
      s_size  <= SZ_BYTE;
      s_addr  <= 2'd0;
      s_rdata <= '0;
      s_src   <= '0;
    end else begin
      s_valid <= acc_valid;
      s_store <= acc_store;
      s_swap  <= acc_brev ^ le_mode;
      s_size  <= acc_size;
      s_addr  <= addr_lo;
      s_rdata <= cache_rdata;
      s_src   <= store_src;
    end
  end

  logic [31:0] byte_sh, ld_val, st_data_n;
  logic [15:0] ld_half, st_half;
  logic [3:0]  st_be_n;

  assign byte_sh = s_rdata >> {s_addr, 3'b000};
  assign ld_half = s_addr[1] ? s_rdata[31:16] : s_rdata[15:0];
  assign st_half = s_swap ? s_src[15:0] : {s_src[7:0], s_src[15:8]};

  always_comb begin
    case (s_size)
      SZ_BYTE: ld_val = {24'd0, byte_sh[7:0]};
      SZ_HALF: ld_val = {16'd0, s_swap ? ld_half : {ld_half[7:0], ld_half[15:8]}};
      default: ld_val = s_swap ? s_rdata : bswap(s_rdata);
    endcase
  end

  always_comb begin
    case (s_size)
      SZ_BYTE: begin
        st_be_n   = 4'b0001 << s_addr;
        st_data_n = {24'd0, s_src[7:0]} << {s_addr, 3'b000};
      end
      SZ_HALF: begin
        st_be_n   = s_addr[1] ? 4'b1100 : 4'b0011;
        st_data_n = s_addr[1] ? {st_half, 16'd0} : {16'd0, st_half};
      end
      default: begin
        st_be_n   = 4'b1111;
        st_data_n = s_swap ? s_src : bswap(s_src);
      end
    endcase
  end

  wire ld_fire = s_valid && !s_store;
  wire st_fire = s_valid && s_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_data  <= '0;
      st_valid <= 1'b0;
      st_be    <= '0;
      st_data  <= '0;
    end else begin
      wb_valid <= ld_fire;
      if (ld_fire) wb_data <= ld_val;
      st_valid <= st_fire;
      st_be    <= st_fire ? st_be_n : 4'd0;
      st_data  <= st_fire ? st_data_n : 32'd0;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(s_valid && !s_store));
  p_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && st_valid));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |-> (st_be == 4'd0 && st_data == 32'd0));
  p_be_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111}));
  p_dead_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> ((st_data & ~{{8{st_be[3]}}, {8{st_be[2]}}, {8{st_be[1]}}, {8{st_be[0]}}}) == 32'd0));
  p_byte_zext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && $past(s_size == SZ_BYTE)) |-> (wb_data[31:8] == 24'd0));
  p_decode_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(decode_word) == $countones(fetch_word));
endmodule

// File: tb/endian_lane_steer_test.sv
module endian_lane_steer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_store = 1'b0, acc_brev = 1'b0, le_mode = 1'b0;
  logic [1:0]  acc_size = 2'd0, addr_lo = 2'd0;
  logic [31:0] cache_rdata = '0, store_src = '0, fetch_word = '0;
  logic [31:0] decode_word, wb_data, st_data;
  logic        wb_valid, st_valid;
  logic [3:0]  st_be;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  endian_lane_steer uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_store(acc_store),
    .acc_size(acc_size), .acc_brev(acc_brev), .le_mode(le_mode), .addr_lo(addr_lo),
    .cache_rdata(cache_rdata), .store_src(store_src), .fetch_word(fetch_word),
    .decode_word(decode_word), .wb_valid(wb_valid), .wb_data(wb_data),
    .st_valid(st_valid), .st_be(st_be), .st_data(st_data)
  );

  // {store, size[1:0], brev, le, addr[1:0], data_in[31:0], exp_data[31:0], exp_be[3:0]}
  localparam logic [74:0] VECS [12] = '{
    {1'b0, 2'd0, 1'b1, 1'b0, 2'd2, 32'hD4C3B2A1, 32'h000000C3, 4'h0}, // R2
    {1'b0, 2'd1, 1'b0, 1'b0, 2'd2, 32'hD4C3B2A1, 32'h0000C3D4, 4'h0}, // R3
    {1'b0, 2'd1, 1'b0, 1'b0, 2'd3, 32'hD4C3B2A1, 32'h0000C3D4, 4'h0}, // R3
    {1'b0, 2'd1, 1'b1, 1'b0, 2'd0, 32'hD4C3B2A1, 32'h0000B2A1, 4'h0}, // R4
    {1'b0, 2'd2, 1'b0, 1'b0, 2'd1, 32'hD4C3B2A1, 32'hA1B2C3D4, 4'h0}, // R5
    {1'b0, 2'd2, 1'b0, 1'b1, 2'd0, 32'hD4C3B2A1, 32'hD4C3B2A1, 4'h0}, // R4
    {1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 32'hD4C3B2A1, 32'hA1B2C3D4, 4'h0}, // R6
    {1'b1, 2'd0, 1'b0, 1'b1, 2'd1, 32'h11223344, 32'h00004400, 4'h2}, // R9
    {1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 32'h11223344, 32'h44330000, 4'hC}, // R8
    {1'b1, 2'd1, 1'b1, 1'b0, 2'd0, 32'h11223344, 32'h00003344, 4'h3}, // R9
    {1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'h11223344, 32'h44332211, 4'hF}, // R9
    {1'b1, 2'd3, 1'b0, 1'b1, 2'd2, 32'h11223344, 32'h11223344, 4'hF}  // R8
  };

  task automatic check(input string req, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_access(input logic st, input logic [1:0] sz, input logic br,
                            input logic le, input logic [1:0] ad, input logic [31:0] din);
    @(negedge clk);
    acc_valid = 1'b1; acc_store = st; acc_size = sz; acc_brev = br;
    le_mode = le; addr_lo = ad;
    if (st) store_src = din; else cache_rdata = din;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic sw,
                                           input logic [1:0] ad, input logic [31:0] rd);
    logic [7:0] l [4];
    int b;
    for (int k = 0; k < 4; k++) l[k] = rd[8*k +: 8];
    b = ad[1] ? 2 : 0;
    if (sz == 2'd0) return {24'd0, l[ad]};
    if (sz == 2'd1) return sw ? {16'd0, l[b+1], l[b]} : {16'd0, l[b], l[b+1]};
    return sw ? {l[3], l[2], l[1], l[0]} : {l[0], l[1], l[2], l[3]};
  endfunction

  function automatic logic [35:0] ref_store(input logic [1:0] sz, input logic sw,
                                            input logic [1:0] ad, input logic [31:0] s);
    logic [7:0] l [4];
    logic [3:0] be;
    int b;
    for (int k = 0; k < 4; k++) l[k] = 8'd0;
    be = 4'd0;
    b = ad[1] ? 2 : 0;
    if (sz == 2'd0) begin
      l[ad] = s[7:0]; be[ad] = 1'b1;
    end else if (sz == 2'd1) begin
      l[b]   = sw ? s[7:0] : s[15:8];
      l[b+1] = sw ? s[15:8] : s[7:0];
      be[b] = 1'b1; be[b+1] = 1'b1;
    end else begin
      for (int k = 0; k < 4; k++) l[k] = sw ? s[8*k +: 8] : s[8*(3-k) +: 8];
      be = 4'hF;
    end
    return {be, l[3], l[2], l[1], l[0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1", {wb_valid, st_valid, st_be, 30'd0}, 36'd0);
    check("R1", {4'd0, wb_data}, 36'd0);
    check("R1", {4'd0, st_data}, 36'd0);
    rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      run_access(VECS[i][74], VECS[i][73:72], VECS[i][71], VECS[i][70],
                 VECS[i][69:68], VECS[i][67:36]);
      if (VECS[i][74]) begin
        check("R8/R9 table", {st_be, st_data}, {VECS[i][3:0], VECS[i][35:4]});
        check("R7 table", {35'd0, st_valid}, 36'd1);
      end else begin
        check("R2-R6 table", {4'd0, wb_data}, {4'd0, VECS[i][35:4]});
        check("R7 table", {35'd0, wb_valid}, 36'd1);
      end
    end

    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 4; sz++)
        for (int m = 0; m < 4; m++)
          for (int ad = 0; ad < 4; ad++) begin
            logic [31:0] din;
            din = 32'h8F5E2A17 ^ (st * 32'h01010101) ^ (ad * 32'h30507090);
            run_access(st[0], sz[1:0], m[1], m[0], ad[1:0], din);
            if (st == 1)
              check("R6/R8/R9 sweep", {st_be, st_data},
                    ref_store(sz[1:0], m[1] ^ m[0], ad[1:0], din));
            else
              check("R2/R3/R4/R5/R6 sweep", {4'd0, wb_data},
                    {4'd0, ref_load(sz[1:0], m[1] ^ m[0], ad[1:0], din)});
          end

    // R7: reversed load is not ready after one edge, ready after two
    @(negedge clk);
    acc_valid = 1'b1; acc_store = 1'b0; acc_size = 2'd2; acc_brev = 1'b1;
    le_mode = 1'b0; addr_lo = 2'd0; cache_rdata = 32'hCAFE0123;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    check("R7 one edge", {35'd0, wb_valid}, 36'd0);
    @(posedge clk); @(negedge clk);
    check("R7 two edges", {3'd0, wb_valid, wb_data}, {4'd1, 32'hCAFE0123});
    @(posedge clk); @(negedge clk);
    check("R7 single pulse", {35'd0, wb_valid}, 36'd0);

    // R11: store does not disturb wb_data; R8: load leaves st_be zero
    held = wb_data;
    run_access(1'b1, 2'd2, 1'b0, 1'b0, 2'd0, 32'h55AA55AA);
    check("R11", {4'd0, wb_data}, {4'd0, held});
    run_access(1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 32'h0000BEEF);
    check("R8 load no enables", {st_be, st_data}, 36'd0);

    // R10: instruction path
    @(negedge clk);
    fetch_word = 32'h12345678; le_mode = 1'b0;
    #1 check("R10 be", {4'd0, decode_word}, {4'd0, 32'h12345678});
    le_mode = 1'b1;
    #1 check("R10 le", {4'd0, decode_word}, {4'd0, 32'h78563412});
    le_mode = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule